// File: doc/BRIEF.md
# Phase-Continuous Trigger Clock with Octave Divider

This block generates a periodic trigger from a fixed system clock. A phase accumulator of `ACC_W` bits adds a programmable increment every cycle. Its wraparound (carry out) marks one period of a base frequency `Fclk * inc / 2^ACC_W`. The increment is meant to keep that base frequency in the top 2:1 range. A power-of-two divider then counts these wraps and stretches the period by `2^exp`, which reaches the low frequencies without a very small increment. The divider output passes through one output register to give a single-cycle trigger pulse.

Software-side logic writes a new increment and exponent into holding registers with a write strobe. A separate update cue copies both into the working registers on the same clock edge. The accumulator keeps its phase and the divider keeps its count across that edge. A retune therefore produces exactly one transition interval, and no stray or runaway trigger. If the divider count already meets the new terminal count when the cue arrives, the divider fires in that same cycle.

Top module: `dds_trig_clk`

## Requirements
- R1: After reset the working increment and exponent are zero and `trigOut` stays low until a nonzero setting is committed.
- R2: A write strobe without an update cue loads only the holding registers. The trigger interval does not change.
- R3: An update cue alone copies the held increment and exponent into the working registers together. The new interval applies from then on.
- R4: When the write strobe and the update cue are high in the same cycle, the values present on `freqWord` and `divExp` in that cycle are committed directly.
- R5: With a steady setting (inc, e), every trigger interval is floor or ceil of `2^e * 2^ACC_W / inc` cycles. This holds for every exponent, up to the largest exponent `2^EXP_W - 1`.
- R6: `trigOut` is high for exactly one cycle. It rises one cycle after the clock edge on which the accumulator wrap completes the divider count, or one cycle after the commit edge on which the divider fires at once.
- R7: A commit never clears the accumulator. The wrap after a commit happens where the old phase plus the new increment crosses `2^ACC_W`.
- R8: A commit keeps the divider count. If the count of wraps since the last trigger is at least `2^newExp`, the trigger fires on the commit edge itself. Otherwise counting continues, and the trigger fires on the wrap that brings the count to `2^newExp`.
- R9: When a commit changes only the increment or only the exponent, each trigger interval lies between the old and new steady intervals, within two cycles of quantisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| freqWord | input | ACC_W | Accumulator increment to hold |
| divExp | input | EXP_W | Divider exponent to hold (divide by 2^divExp) |
| wrStb | input | 1 | Loads freqWord and divExp into the holding registers |
| updCue | input | 1 | Commits the held (or bypassed) setting to the working registers |
| trigOut | output | 1 | Single-cycle trigger pulse |

## Verification
Three things can land in one cycle. The commit edge can coincide with an accumulator wrap. The commit can also meet a divider count that already exceeds the new terminal count, and the write strobe can coincide with the cue. The bench places a cue exactly on cycles whose accumulator phase it knows from a reset-aligned increment. It then checks whether the trigger comes on the commit edge, on the next wrap, or where the preserved phase dictates. A long random run then retunes either the increment or the exponent at arbitrary phases. Every measured interval is judged against the steady periods of the settings in force during that interval.

// File: rtl/dds_trig_pkg.sv
package dds_trig_pkg;

  // Strobes the configuration control hands to the datapath.
  typedef struct packed {
    logic commit;   // working registers take the next setting at this edge
  } cfgStrb_t;

endpackage

// File: rtl/trig_cfg_ctrl.sv
module trig_cfg_ctrl
  import dds_trig_pkg::*;
#(
  parameter int INC_W = 48,
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [INC_W-1:0] freqWord,
  input  logic [EXP_W-1:0] divExp,
  input  logic             wrStb,
  input  logic             updCue,
  output cfgStrb_t         strb,
  output logic [INC_W-1:0] curInc,
  output logic [EXP_W-1:0] curExp,
  output logic [EXP_W-1:0] nextExp
);

  logic [INC_W-1:0] holdInc;
  logic [EXP_W-1:0] holdExp;
  logic [INC_W-1:0] nextInc;

  // Same-cycle write and cue: the incoming values win over the held ones.
  always_comb begin
    nextInc = wrStb ? freqWord : holdInc;
    nextExp = wrStb ? divExp   : holdExp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdInc <= '0;
      holdExp <= '0;
    end else if (wrStb) begin
      holdInc <= freqWord;
      holdExp <= divExp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curInc <= '0;
      curExp <= '0;
    end else if (updCue) begin
      curInc <= nextInc;
      curExp <= nextExp;
    end
  end

  always_comb strb.commit = updCue;

  // R3: without a cue the working setting never moves
  p_hold_active_r3: assert property (@(posedge clk) disable iff (!rstN)
    !updCue |=> ($stable(curInc) && $stable(curExp)));

  // R4: write and cue together commit the port values of that cycle
  p_bypass_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && updCue) |=> (curInc == $past(freqWord) && curExp == $past(divExp)));

endmodule

// File: rtl/trig_oct_div.sv
module trig_oct_div #(
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             commit,
  input  logic [EXP_W-1:0] curExp,
  input  logic [EXP_W-1:0] nextExp,
  output logic             fire
);

  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CNT_W   = MAX_EXP + 1;

  logic [CNT_W-1:0] wrapCnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] termVal;
  logic [EXP_W-1:0] effExp;

  // On the commit edge the new exponent is judged against the kept count.
  always_comb begin
    effExp  = commit ? nextExp : curExp;
    termVal = CNT_W'(1) << effExp;
    cntNext = wrapCnt + CNT_W'(tick);
    fire    = (cntNext >= termVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN)     wrapCnt <= '0;
    else if (fire) wrapCnt <= '0;
    else           wrapCnt <= cntNext;
  end

  // R8: the kept count never rests at or beyond the working terminal count
  p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrapCnt < (CNT_W'(1) << curExp));

endmodule

// File: rtl/trig_phase_path.sv
module trig_phase_path
  import dds_trig_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrb_t         strb,
  input  logic [ACC_W-1:0] curInc,
  input  logic [EXP_W-1:0] curExp,
  input  logic [EXP_W-1:0] nextExp,
  output logic             trigOut
);

  logic [ACC_W-1:0] phaseAcc;
  logic [ACC_W:0]   sumWide;
  logic             wrapTick;
  logic             divFire;

  always_comb begin
    sumWide  = {1'b0, phaseAcc} + {1'b0, curInc};
    wrapTick = sumWide[ACC_W];
  end

  // Phase runs on through every commit; only reset clears it.
  always_ff @(posedge clk) begin
    if (!rstN) phaseAcc <= '0;
    else       phaseAcc <= sumWide[ACC_W-1:0];
  end

  trig_oct_div #(.EXP_W(EXP_W)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (wrapTick),
    .commit  (strb.commit),
    .curExp  (curExp),
    .nextExp (nextExp),
    .fire    (divFire)
  );

  always_ff @(posedge clk) begin
    if (!rstN) trigOut <= 1'b0;
    else       trigOut <= divFire;
  end

  // R6: a pulse follows only a wrap or a commit of the previous cycle
  p_pulse_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(wrapTick || strb.commit));

  // R1: a zero increment with no commit yields no pulse
  p_zero_inc_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (curInc == '0 && !strb.commit) |=> !trigOut);

endmodule

// File: rtl/dds_trig_clk.sv
module dds_trig_clk
  import dds_trig_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ACC_W-1:0] freqWord,
  input  logic [EXP_W-1:0] divExp,
  input  logic             wrStb,
  input  logic             updCue,
  output logic             trigOut
);

  cfgStrb_t         strb;
  logic [ACC_W-1:0] curInc;
  logic [EXP_W-1:0] curExp;
  logic [EXP_W-1:0] nextExp;

  trig_cfg_ctrl #(.INC_W(ACC_W), .EXP_W(EXP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .freqWord (freqWord),
    .divExp   (divExp),
    .wrStb    (wrStb),
    .updCue   (updCue),
    .strb     (strb),
    .curInc   (curInc),
    .curExp   (curExp),
    .nextExp  (nextExp)
  );

  trig_phase_path #(.ACC_W(ACC_W), .EXP_W(EXP_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .curInc  (curInc),
    .curExp  (curExp),
    .nextExp (nextExp),
    .trigOut (trigOut)
  );

endmodule

// File: tb/dds_trig_clk_bench.sv
module dds_trig_clk_bench;

  localparam int ACC_W = 8;
  localparam int EXP_W = 3;
  localparam longint MOD = longint'(1) << ACC_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [ACC_W-1:0] freqWord = '0;
  logic [EXP_W-1:0] divExp = '0;
  logic             wrStb = 1'b0;
  logic             updCue = 1'b0;
  logic             trigOut;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // bench model of the settings in force
  int mInc = 0, mExp = 0, hInc = 0, hExp = 0;
  bit boundOn = 0, refValid = 0;
  int mSince = 0;
  longint loB = 0, hiB = 0;

  dds_trig_clk #(.ACC_W(ACC_W), .EXP_W(EXP_W)) u_dds_trig_clk (
    .clk(clk), .rstN(rstN), .freqWord(freqWord), .divExp(divExp),
    .wrStb(wrStb), .updCue(updCue), .trigOut(trigOut)
  );

  always #5 clk = ~clk;

  function automatic longint pFloor(int inc, int e);
    return ((longint'(1) << e) * MOD) / inc;
  endfunction

  function automatic longint pCeil(int inc, int e);
    return ((longint'(1) << e) * MOD + inc - 1) / inc;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Caller sits just after a falling edge; the setting reaches the next rising edge.
  task automatic drive(input int inc, input int e, input bit wr, input bit cue);
    freqWord = ACC_W'(inc);
    divExp   = EXP_W'(e);
    wrStb    = wr;
    updCue   = cue;
    if (cue) begin
      mInc = wr ? inc : hInc;
      mExp = wr ? e : hExp;
    end
    if (wr) begin hInc = inc; hExp = e; end
    @(negedge clk);
    wrStb  = 1'b0;
    updCue = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    mInc = 0; mExp = 0; hInc = 0; hExp = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitTrig(output bit seen);
    int n = 0;
    seen = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trigOut && n < 4000);
    seen = trigOut;
  endtask

  task automatic gapToNext(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!trigOut && g < 4000);
  endtask

  // Interval monitor for the bounded-transition rule (R9)
  always @(negedge clk) begin
    if (!rstN) begin
      mSince = 0;
      refValid = 0;
    end else begin
      mSince++;
      if (mInc != 0) begin
        if (pFloor(mInc, mExp) < loB) loB = pFloor(mInc, mExp);
        if (pCeil(mInc, mExp) > hiB)  hiB = pCeil(mInc, mExp);
      end
      if (trigOut) begin
        if (boundOn && refValid) begin
          nVec++;
          if (mSince < loB - 2 || mSince > hiB + 2) begin
            nBad++;
            $display("FAIL R9 interval actual=%0d expected=%0d..%0d", mSince, loB - 2, hiB + 2);
          end
        end
        refValid = boundOn;
        mSince = 0;
        if (mInc != 0) begin
          loB = pFloor(mInc, mExp);
          hiB = pCeil(mInc, mExp);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    bit seen;
    int g, hits;
    int expsList[6] = '{0, 1, 2, 3, 4, 7};

    // R1: reset state, no trigger with a zero working setting
    doReset();
    chk(trigOut == 1'b0, "R1 reset output", trigOut, 0);
    hits = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (trigOut) hits++;
    end
    chk(hits == 0, "R1 quiet after reset", hits, 0);

    // R4: write and cue together, held registers still zero
    drive(128, 0, 1, 1);
    waitTrig(seen);
    chk(seen, "R4 bypass commit starts triggers", seen, 1);
    // R6: single-cycle pulse
    @(negedge clk);
    chk(trigOut == 1'b0, "R6 pulse width one cycle", trigOut, 0);
    @(negedge clk);
    chk(trigOut == 1'b1, "R4 interval inc=128 e=0", trigOut, 1);

    // R2: write without cue leaves the interval at 2
    drive(64, 2, 1, 0);
    waitTrig(seen);
    for (int i = 0; i < 4; i++) begin
      gapToNext(g);
      chk(g == 2, "R2 held write ignored", g, 2);
    end

    // R3: cue alone commits the held pair
    drive(0, 0, 0, 1);
    waitTrig(seen);
    waitTrig(seen);
    for (int i = 0; i < 3; i++) begin
      gapToNext(g);
      chk(g == 16, "R3 cue commits held setting", g, 16);
    end

    // R7: phase survives commit (inc 64, acc multiples of 64)
    doReset();
    drive(64, 0, 1, 1);
    waitTrig(seen);               // after edge X, phase is 0
    drive(255, 0, 1, 1);          // commit at X+1, phase 64 kept
    chk(trigOut == 1'b0, "R7 no pulse on commit edge", trigOut, 0);
    @(negedge clk);
    chk(trigOut == 1'b1, "R7 wrap from kept phase", trigOut, 1);

    // R8: fire at once when the kept count already meets the new terminal
    doReset();
    drive(128, 3, 1, 1);
    waitTrig(seen);               // after edge X, count 0
    repeat (6) @(negedge clk);    // wraps at X+2, X+4, X+6 -> count 3
    drive(128, 1, 1, 1);          // commit at X+7 with no wrap
    chk(trigOut == 1'b1, "R8 fire on commit edge", trigOut, 1);
    @(negedge clk);
    chk(trigOut == 1'b0, "R8 no repeat after immediate fire", trigOut, 0);

    // R8: count below new terminal keeps counting
    drive(128, 3, 1, 1);
    waitTrig(seen);               // after edge X
    repeat (2) @(negedge clk);    // wrap at X+2 -> count 1
    drive(128, 1, 1, 1);          // commit at X+3
    chk(trigOut == 1'b0, "R8 count kept, no early fire", trigOut, 0);
    @(negedge clk);
    chk(trigOut == 1'b1, "R8 fire on wrap reaching new terminal", trigOut, 1);

    // R5: steady intervals across increments and exponents
    foreach (expsList[ei]) begin
      for (int k = 0; k < 4; k++) begin
        int inc;
        int e;
        longint lo, hi;
        inc = 64 + k * 21;
        e = expsList[ei];
        if (e == 7 && k != 3) continue;
        lo = pFloor(inc, e);
        hi = pCeil(inc, e);
        drive(inc, e, 1, 1);
        waitTrig(seen);
        waitTrig(seen);
        for (int j = 0; j < 6; j++) begin
          gapToNext(g);
          chk(g == lo || g == hi, "R5 steady interval", g, lo);
        end
      end
    end

    // R9: random single-knob retunes at arbitrary phase
    drive(100, 2, 1, 1);
    boundOn = 1;
    for (int it = 0; it < 200; it++) begin
      int inc = mInc;
      int e = mExp;
      if ($urandom_range(0, 1) == 0) inc = $urandom_range(64, 127);
      else e = $urandom_range(0, 4);
      if ($urandom_range(0, 3) == 0) begin
        drive(inc, e, 1, 0);
        repeat ($urandom_range(0, 20)) @(negedge clk);
        drive(0, 0, 0, 1);
      end else begin
        drive(inc, e, 1, 1);
      end
      repeat ($urandom_range(20, 300)) @(negedge clk);
    end
    boundOn = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule